// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns bytes written by a host into an asynchronous serial stream on one output line. The host writes a byte with a single-cycle strobe whenever the holding-empty flag is high. The byte waits in a holding register until the frame engine is idle. It then moves into a shift register and is sent as a start bit, 5 to 8 data bits (least significant first), an optional parity bit and a stop period.

Bit timing comes from an external enable pulse that runs at sixteen times the bit rate. Every bit lasts 16 pulses. The stop period lasts 16, 24 or 32 pulses. The frame format is taken from the configuration inputs at the moment a byte enters the shift register. The host can also command a line break: the line is held low for as long as the command is present, then held high for one configured stop period before normal traffic resumes.

Top module: `sertx_top`

## Requirements
- R1: After reset, txd is 1, hold_empty is 1 and tx_empty is 1.
- R2: A frame starts with txd low for 16 ticks. It continues with cfg_len+5 data bits, least significant bit first, 16 ticks each. cfg_len 00 means 5 bits and 11 means 8 bits.
- R3: cfg_par selects the parity bit, sent for 16 ticks after the data. 000 means none, 001 means even, 010 means odd, 100 means a fixed 0 and 101 means a fixed 1. Every other code means none. Parity covers only the bits that are sent.
- R4: The stop period is high and lasts 16 ticks for cfg_stop 00, 24 ticks for 01, and 32 ticks for 10 or 11.
- R5: Format inputs are captured when a byte enters the shift register. A change during a frame has no effect on that frame.
- R6: A write is accepted when hold_empty is 1, and hold_empty is 0 in the next cycle. When the frame engine is idle, the byte moves to the shift register one clock later, and hold_empty is 1 again on the clock after that.
- R7: A byte that waits in the holding register starts its frame directly after the current stop period ends, with only a single idle clock between the two frames.
- R8: tx_empty is 1 only when the holding register is empty and no frame, break or break recovery is in progress.
- R9: A write while hold_empty is 0 is ignored. Neither the pending byte nor the frame in progress changes.
- R10: When brk_cmd is high and the engine is idle, txd goes low in the next cycle and stays low while brk_cmd stays high. A frame in progress completes first. A break takes priority over a pending byte.
- R11: After brk_cmd falls, txd is high for one stop period, set by cfg_stop at release, before any pending byte is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Enable pulse at 16x the bit rate |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| cfg_len | input | 2 | Data length code (bit count minus 5) |
| cfg_par | input | 3 | Parity mode code |
| cfg_stop | input | 2 | Stop length code |
| brk_cmd | input | 1 | Line break command |
| txd | output | 1 | Serial output, idle high |
| hold_empty | output | 1 | Holding register can accept a byte |
| tx_empty | output | 1 | Holding register and frame engine both idle |

## Verification
The bench sends frames in each length with every parity mode and each stop code. It compares the line level and both flags with a behavioural model on every clock. This shows whether bits are dropped or extra ones inserted, whether parity is computed over the right bits, and whether the 24-tick stop is cut short or stretched.

Writes are issued back to back and into a full holding register. These patterns show whether a queued byte runs straight into the next frame and whether an ignored write leaks into the line.

The format is changed in the middle of a frame to show whether configuration is captured at load. A break is raised during a frame with a byte pending. This shows whether the frame completes, whether the low level holds for as long as the command stays high, and whether recovery takes one full stop period before the pending byte is sent.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BRK, ST_BRKSTOP
  } sertx_state_e;
endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_empty
);
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              empty_q, empty_d;
  logic              load_en;

  assign load_en = wr_en && empty_q;

  always_comb begin
    hold_d  = hold_q;
    empty_d = empty_q;
    if (load_en) begin
      hold_d  = wr_data;
      empty_d = 1'b0;
    end else if (take) begin
      empty_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      empty_q <= 1'b1;
    end else begin
      if (load_en) hold_q <= hold_d;
      empty_q <= empty_d;
    end
  end

  assign hold_data  = hold_q;
  assign hold_empty = empty_q;

  // R9: a write into a full register leaves the byte and the flag untouched
  a_r9_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !empty_q && !take) |=> (hold_q == $past(hold_q)) && !empty_q);

  // R6: a byte taken by the frame engine frees the register
  a_r6_take_frees: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> empty_q);
endmodule

// File: rtl/sertx_parity.sv
module sertx_parity #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic [1:0]        len_code,
  input  logic [2:0]        mode,
  output logic              par_en,
  output logic              par_bit
);
  localparam int LEN_MIN = DATA_W - 3;

  logic [DATA_W-1:0] keep;
  logic              ones;

  for (genvar i = 0; i < DATA_W; i++) begin : g_keep
    assign keep[i] = (i < LEN_MIN + int'(len_code));
  end

  assign ones = ^(data & keep);

  always_comb begin
    case (mode)
      3'b001:  begin par_en = 1'b1; par_bit = ones;  end
      3'b010:  begin par_en = 1'b1; par_bit = ~ones; end
      3'b100:  begin par_en = 1'b1; par_bit = 1'b0;  end
      3'b101:  begin par_en = 1'b1; par_bit = 1'b1;  end
      default: begin par_en = 1'b0; par_bit = 1'b1;  end
    endcase
  end
endmodule

// File: rtl/sertx_tickcnt.sv
module sertx_tickcnt #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign done   = tick && (cnt_q == limit - 1'b1);
  assign cnt_en = clr || tick;

  always_comb begin
    if (clr || done) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R4: the tick count never passes the length of the current bit
  a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < limit);
endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              brk_cmd,
  input  logic              hold_valid,
  input  logic [DATA_W-1:0] hold_data,
  input  logic [1:0]        cfg_len,
  input  logic [1:0]        cfg_stop,
  input  logic              par_en,
  input  logic              par_bit,
  output logic              pop,
  output logic              idle,
  output logic              txd
);
  localparam int LEN_MIN = DATA_W - 3;
  localparam int IDX_W   = $clog2(DATA_W);
  localparam int CNT_W   = $clog2(2 * OVS + 1);

  sertx_state_e      state_q, state_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [IDX_W-1:0]  idx_q, idx_d, idx_last;
  logic [1:0]        len_q, len_d, stop_q, stop_d;
  logic              pen_q, pen_d, pbit_q, pbit_d;
  logic [CNT_W-1:0]  limit;
  logic              done, cnt_clr;

  function automatic logic [CNT_W-1:0] stop_ticks(input logic [1:0] code);
    case (code)
      2'b00:   return CNT_W'(OVS);
      2'b01:   return CNT_W'(OVS + OVS / 2);
      default: return CNT_W'(2 * OVS);
    endcase
  endfunction

  assign limit    = (state_q == ST_STOP || state_q == ST_BRKSTOP) ?
                    stop_ticks(stop_q) : CNT_W'(OVS);
  assign cnt_clr  = (state_q == ST_IDLE) || (state_q == ST_BRK);
  assign idx_last = IDX_W'(LEN_MIN - 1) + IDX_W'(len_q);

  sertx_tickcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .tick  (tick),
    .limit (limit),
    .done  (done)
  );

  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    idx_d   = idx_q;
    len_d   = len_q;
    stop_d  = stop_q;
    pen_d   = pen_q;
    pbit_d  = pbit_q;
    pop     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (brk_cmd) begin
          state_d = ST_BRK;
        end else if (hold_valid) begin
          state_d = ST_START;
          pop     = 1'b1;
          sh_d    = hold_data;
          len_d   = cfg_len;
          stop_d  = cfg_stop;
          pen_d   = par_en;
          pbit_d  = par_bit;
        end
      end
      ST_START: if (done) begin
        state_d = ST_DATA;
        idx_d   = '0;
      end
      ST_DATA: if (done) begin
        if (idx_q == idx_last) begin
          state_d = pen_q ? ST_PAR : ST_STOP;
        end else begin
          sh_d  = sh_q >> 1;
          idx_d = idx_q + 1'b1;
        end
      end
      ST_PAR:     if (done) state_d = ST_STOP;
      ST_STOP:    if (done) state_d = ST_IDLE;
      ST_BRK: if (!brk_cmd) begin
        state_d = ST_BRKSTOP;
        stop_d  = cfg_stop;
      end
      ST_BRKSTOP: if (done) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      idx_q   <= '0;
      len_q   <= '0;
      stop_q  <= '0;
      pen_q   <= 1'b0;
      pbit_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      idx_q   <= idx_d;
      len_q   <= len_d;
      stop_q  <= stop_d;
      pen_q   <= pen_d;
      pbit_q  <= pbit_d;
    end
  end

  always_comb begin
    case (state_q)
      ST_START: txd = 1'b0;
      ST_DATA:  txd = sh_q[0];
      ST_PAR:   txd = pbit_q;
      ST_BRK:   txd = 1'b0;
      default:  txd = 1'b1;
    endcase
  end

  assign idle = (state_q == ST_IDLE);

  // R2: a loaded byte is followed by the start bit in the next cycle
  a_r2_start_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !txd);

  // R10: a break command at idle pulls the line low in the next cycle
  a_r10_break_low: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && brk_cmd) |=> !txd);

  // R11: releasing the break returns the line high
  a_r11_release_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BRK && !brk_cmd) |=> txd);
endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        cfg_len,
  input  logic [2:0]        cfg_par,
  input  logic [1:0]        cfg_stop,
  input  logic              brk_cmd,
  output logic              txd,
  output logic              hold_empty,
  output logic              tx_empty
);
  logic [DATA_W-1:0] hold_data;
  logic              pop, idle, par_en, par_bit;

  sertx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .take       (pop),
    .hold_data  (hold_data),
    .hold_empty (hold_empty)
  );

  sertx_parity #(.DATA_W(DATA_W)) u_par (
    .data     (hold_data),
    .len_code (cfg_len),
    .mode     (cfg_par),
    .par_en   (par_en),
    .par_bit  (par_bit)
  );

  sertx_framer #(.DATA_W(DATA_W), .OVS(OVS)) u_frm (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick16),
    .brk_cmd    (brk_cmd),
    .hold_valid (!hold_empty),
    .hold_data  (hold_data),
    .cfg_len    (cfg_len),
    .cfg_stop   (cfg_stop),
    .par_en     (par_en),
    .par_bit    (par_bit),
    .pop        (pop),
    .idle       (idle),
    .txd        (txd)
  );

  assign tx_empty = idle && hold_empty;

  // R6: the frame engine only takes a byte that is present
  a_r6_pop_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !hold_empty);

  // R8: a busy frame engine keeps tx_empty low in the next cycle
  a_r8_busy_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !tx_empty);
endmodule

// File: tb/sertx_top_tb.sv
module sertx_top_tb;
  logic       clk = 1'b0;
  logic       rst_n, tick16, wr_en, brk_cmd;
  logic [7:0] wr_data;
  logic [1:0] cfg_len, cfg_stop;
  logic [2:0] cfg_par;
  logic       txd, hold_empty, tx_empty;

  int  n_run = 0, n_fail = 0;
  bit  cmp_on = 0, finished = 0;
  int  tdiv;

  always #4 clk = ~clk;

  sertx_top u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_en(wr_en),
    .wr_data(wr_data), .cfg_len(cfg_len), .cfg_par(cfg_par),
    .cfg_stop(cfg_stop), .brk_cmd(brk_cmd), .txd(txd),
    .hold_empty(hold_empty), .tx_empty(tx_empty)
  );

  always @(negedge clk) begin
    if (!rst_n) begin
      tdiv = 0; tick16 = 1'b0;
    end else begin
      tdiv = (tdiv == 2) ? 0 : tdiv + 1;
      tick16 = (tdiv == 0);
    end
  end

  // behavioural model: phase 0 idle, 1 start, 2 data, 3 parity, 4 stop, 5 break, 6 break recovery
  int       m_phase, m_cnt, m_bit, m_len, m_stopt;
  bit       m_full, m_pen, m_pbit;
  bit [7:0] m_hold, m_sh;

  function automatic int stop_len(input logic [1:0] c);
    return (c == 2'b00) ? 16 : (c == 2'b01) ? 24 : 32;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_bit = 0; m_len = 8; m_stopt = 16;
      m_full = 0; m_pen = 0; m_pbit = 1; m_hold = 0; m_sh = 0;
    end else begin
      int  lim, nph, ncnt, ones;
      bit  done, take;
      lim  = (m_phase == 4 || m_phase == 6) ? m_stopt : 16;
      done = tick16 && (m_cnt == lim - 1);
      take = (m_phase == 0) && !brk_cmd && m_full;
      nph  = m_phase;
      if (m_phase == 0 || m_phase == 5) ncnt = 0;
      else if (tick16) ncnt = done ? 0 : m_cnt + 1;
      else ncnt = m_cnt;
      case (m_phase)
        0: if (brk_cmd) nph = 5;
           else if (m_full) begin
             nph = 1; m_sh = m_hold; m_len = int'(cfg_len) + 5;
             m_stopt = stop_len(cfg_stop);
             ones = 0;
             for (int i = 0; i < m_len; i++) ones += m_hold[i];
             m_pen = 1;
             case (cfg_par)
               3'b001: m_pbit = ones[0];
               3'b010: m_pbit = !ones[0];
               3'b100: m_pbit = 0;
               3'b101: m_pbit = 1;
               default: begin m_pen = 0; m_pbit = 1; end
             endcase
           end
        1: if (done) begin nph = 2; m_bit = 0; end
        2: if (done) begin
             if (m_bit == m_len - 1) nph = m_pen ? 3 : 4;
             else begin m_sh = m_sh >> 1; m_bit++; end
           end
        3: if (done) nph = 4;
        4: if (done) nph = 0;
        5: if (!brk_cmd) begin nph = 6; m_stopt = stop_len(cfg_stop); end
        default: if (done) nph = 0;
      endcase
      if (wr_en && !m_full) begin m_hold = wr_data; m_full = 1; end
      else if (take) m_full = 0;
      m_phase = nph; m_cnt = ncnt;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic string line_req(input int ph);
    case (ph)
      1, 2:    return "R2 start/data";
      3:       return "R3 parity";
      4:       return "R4 stop";
      5:       return "R10 break";
      6:       return "R11 break recovery";
      default: return "R7 idle line";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      bit etx;
      case (m_phase)
        1, 5:    etx = 0;
        2:       etx = m_sh[0];
        3:       etx = m_pbit;
        default: etx = 1;
      endcase
      chk(txd == etx, line_req(m_phase), txd, etx);
      chk(hold_empty == !m_full, "R6/R9 hold_empty", hold_empty, !m_full);
      chk(tx_empty == (m_phase == 0 && !m_full), "R8 tx_empty", tx_empty,
          (m_phase == 0 && !m_full));
    end
  end

  task automatic put(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_flag_empty();
    while (!tx_empty) @(negedge clk);
  endtask

  task automatic wait_hold();
    while (!hold_empty) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] l, input logic [2:0] p, input logic [1:0] s);
    @(negedge clk); cfg_len = l; cfg_par = p; cfg_stop = s;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick16 = 1'b0; wr_en = 1'b0; wr_data = 8'h00; brk_cmd = 1'b0;
    cfg_len = 2'b11; cfg_par = 3'b000; cfg_stop = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    chk(txd == 1'b1, "R1 txd", txd, 1);
    chk(hold_empty == 1'b1, "R1 hold_empty", hold_empty, 1);
    chk(tx_empty == 1'b1, "R1 tx_empty", tx_empty, 1);
    cmp_on = 1;

    // R2 eight data bits, no parity, one stop
    put(8'hA5);
    chk(hold_empty == 1'b0, "R6 flag low after write", hold_empty, 0);
    @(negedge clk);
    chk(hold_empty == 1'b1, "R6 flag set after move", hold_empty, 1);
    wait_flag_empty();

    // R3 even parity on five bits, R4 one-and-a-half stop, R7 back to back
    set_cfg(2'b00, 3'b001, 2'b01);
    put(8'hF3); put(8'h0C);
    wait_flag_empty();

    // R3 odd parity seven bits, R4 two stops, R9 write into full register
    set_cfg(2'b10, 3'b010, 2'b10);
    put(8'h5C); put(8'h3A); put(8'hFF);
    wait_flag_empty();

    // R3 forced levels on six bits, stop code 11
    set_cfg(2'b01, 3'b101, 2'b11);
    put(8'h2B);
    wait_hold();
    set_cfg(2'b01, 3'b100, 2'b11);
    put(8'h71);
    set_cfg(2'b11, 3'b111, 2'b00);
    put(8'h96);
    wait_flag_empty();

    // R5 configuration changes during a frame
    set_cfg(2'b11, 3'b000, 2'b00);
    put(8'h0F);
    repeat (20) @(negedge clk);
    set_cfg(2'b00, 3'b010, 2'b10);
    wait_flag_empty();

    // R10 break during a frame with a byte pending, R11 recovery
    set_cfg(2'b11, 3'b001, 2'b01);
    put(8'h55);
    repeat (30) @(negedge clk);
    brk_cmd = 1'b1;
    put(8'h66);
    repeat (1500) @(negedge clk);
    chk(txd == 1'b0, "R10 line held low", txd, 0);
    chk(tx_empty == 1'b0, "R8 busy in break", tx_empty, 0);
    brk_cmd = 1'b0;
    wait_flag_empty();

    repeat (10) @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule